// File: doc/BRIEF.md
# Buffered SPI Master Byte Engine

This block is the serial side of a host-to-SPI bridge. A host side fills a shared byte buffer and then asks the engine to run one message. The engine pulls one chip-select line low and streams the first `byteCount` buffer bytes onto MOSI. Each byte received on MISO overwrites the buffer entry that was just sent. When the last byte is finished, the engine raises chip select again and pulses `xferDone`.

The transfer format comes from one 8-bit configuration word, which is captured when a start is accepted:

- bits [1:0] pick one of four fixed system-clock dividers for SCK;
- bit 2 selects the clock phase;
- bit 3 selects the idle clock level;
- bit 5 selects the bit order.

Bits 4, 6 and 7 are not used. Words are always 8 bits wide.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, every `csN` line is high, `sck` is low, and both `xferDone` and `bufWrEn` are low.
- R2: A start is accepted only when all of these hold: the engine is idle, `startReq` is high, `byteCount` is between 1 and BUF_DEPTH, and `csSel` has exactly one bit set. On the clock edge that samples an accepted start, the `csN` bit matching the set `csSel` bit goes low.
- R3: A start request is ignored when `byteCount` is 0, when `byteCount` is larger than BUF_DEPTH, or when `csSel` does not have exactly one bit set. An ignored request causes no `csN` activity, no buffer write and no `xferDone`.
- R4: Config bits [1:0] set the SCK divider: 00 gives /4, 01 gives /16, 10 gives /64 and 11 gives /128. Every SCK half period is divider/2 system clocks long. The first SCK edge comes exactly one half period after `csN` goes low. `csN` rises exactly one half period after the last SCK edge.
- R5: Config bit 3 is the idle SCK level. SCK sits at that level whenever no message is running, and it returns to that level after the final edge of a message.
- R6: Config bit 2 selects the phase. When it is 0, each bit is driven before its leading edge and sampled on that leading edge. When it is 1, each bit is driven on its leading edge and sampled on the trailing edge.
- R7: When config bit 5 is 1, each byte is shifted least-significant bit first in both directions. When it is 0, each byte is shifted most-significant bit first.
- R8: A message of n bytes sends buffer entries 0 to n-1 in order, using exactly 16·n SCK edges. The selected `csN` stays low without a break from the first byte to the last.
- R9: For each byte, the received value is written exactly once, to the same buffer address the byte was read from. Entries at index n and above are left untouched.
- R10: `xferDone` is high for exactly one cycle. That cycle is the one after the cycle in which `csN` returns high.
- R11: The configuration, chip select and count are all captured when a start is accepted. Changing `cfgWord`, `csSel` or `byteCount`, or raising `startReq`, while a message is running has no effect on that message.
- R12: No more than one `csN` line is ever low at the same time.

Parameters: NUM_CS is the number of chip-select lines (default 4). BUF_DEPTH is the maximum message length in bytes (default 200).

Buffer read is combinational: `bufRdData` must show the entry at `bufRdAddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWord | input | 8 | Configuration word (divider, phase, polarity, bit order) |
| startReq | input | 1 | Request to start a message |
| byteCount | input | CNT_W | Number of bytes in the message |
| csSel | input | NUM_CS | One-hot choice of chip-select line |
| xferDone | output | 1 | One-cycle pulse when a message has finished |
| bufRdAddr | output | ADDR_W | Buffer read address |
| bufRdData | input | 8 | Buffer read data (combinational) |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrAddr | output | ADDR_W | Buffer write address |
| bufWrData | output | 8 | Received byte to write back |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NUM_CS | Chip selects, active low |

## Verification
The assertions check these properties on every cycle:
- chip select is one-hot-or-none and holds steady through a running message;
- the latched configuration is frozen while a message runs;
- SCK sits at its idle level whenever the engine is not running;
- the sample strobe never coincides with a MOSI change;
- write-backs stay inside the message;
- the edge counter stays within bounds;
- the done pulse is single and follows a chip-select release.

Only the bench scenarios can show the rest, because that needs an independent slave model:
- that the bits arrive in the right order on the right edges for each phase, polarity and bit-order setting;
- that the half period matches each divider code;
- the exact one-half-period gaps at both ends of a message;
- that received data lands back at the right buffer indices;
- that ignored starts and mid-message disturbances really leave the pins and the buffer untouched.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Bit positions inside the configuration word
  localparam int CFG_CPHA_BIT = 2;
  localparam int CFG_CPOL_BIT = 3;
  localparam int CFG_LSB_BIT  = 5;

  // Width of the half-period counter (largest half period is 64)
  localparam int HALF_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } engState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic running;    // a message is in progress (including the done cycle)
    logic start;      // start accepted: load byte 0, set SCK to idle level
    logic idleLvl;    // idle SCK level taken from the incoming config word
    logic load;       // load the shift register from the buffer
    logic shift;      // move the shift register by one bit
    logic capture;    // sample MISO into the capture bit
    logic toggle;     // SCK edge
    logic writeBack;  // register the assembled received byte
  } engStrobe_t;

  // Half-period length in system clocks for a divider code
  function automatic logic [HALF_W-1:0] halfPeriod(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd2;
      2'b01:   return 6'd8;
      2'b10:   return 6'd32;
      default: return 6'd64;
    endcase
  endfunction

endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int BUF_DEPTH = 200,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        cfgWord,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [NUM_CS-1:0] csSel,
  output logic              heldCpha,
  output logic              heldCpol,
  output logic              heldLsb,
  output logic [ADDR_W-1:0] bufRdAddr,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [NUM_CS-1:0] csN,
  output logic              xferDone,
  output engStrobe_t        strobe
);

  localparam int EDGE_W = CNT_W + 4;

  engState_t          state;
  logic [1:0]         divCode;
  logic [CNT_W-1:0]   cntHeld;
  logic [CNT_W-1:0]   byteIdx;
  logic [EDGE_W-1:0]  edgeNo;
  logic [HALF_W-1:0]  divCnt;
  logic [NUM_CS-1:0]  csNReg;
  logic               doneReg;
  logic               wrEnReg;
  logic [ADDR_W-1:0]  wrAddrReg;

  // Bits 7, 6 and 4 of the configuration word are not used
  logic unusedCfgBits;
  assign unusedCfgBits = ^{cfgWord[7:6], cfgWord[4]};

  logic startOk;
  assign startOk = (state == ST_IDLE) && startReq && (byteCount != '0) &&
                   (byteCount <= CNT_W'(BUF_DEPTH)) && $onehot(csSel);

  logic tick, lastTick, leadEdge;
  logic [3:0] edgeInByte;
  assign tick       = (state == ST_RUN) && (divCnt == (halfPeriod(divCode) - 6'd1));
  assign lastTick   = (edgeNo == {cntHeld, 4'b0000});
  assign edgeInByte = edgeNo[3:0];
  assign leadEdge   = ~edgeInByte[0];

  // Read address: phase 0 preloads the next byte at the last trailing edge
  logic [CNT_W-1:0] nextIdx, rdIdx;
  assign nextIdx = byteIdx + 1'b1;
  always_comb begin
    if (state != ST_RUN)                   rdIdx = '0;
    else if (heldCpha || nextIdx >= cntHeld) rdIdx = byteIdx;
    else                                   rdIdx = nextIdx;
  end
  assign bufRdAddr = rdIdx[ADDR_W-1:0];

  always_comb begin
    strobe         = '0;
    strobe.running = (state != ST_IDLE);
    strobe.start   = startOk;
    strobe.idleLvl = cfgWord[CFG_CPOL_BIT];
    if (tick && !lastTick) begin
      strobe.toggle = 1'b1;
      if (!heldCpha) begin
        if (leadEdge) begin
          strobe.capture = 1'b1;
        end else if (edgeInByte == 4'hF) begin
          strobe.writeBack = 1'b1;
          strobe.load      = 1'b1;
        end else begin
          strobe.shift = 1'b1;
        end
      end else begin
        if (leadEdge) begin
          if (edgeInByte == 4'h0) strobe.load  = 1'b1;
          else                    strobe.shift = 1'b1;
        end else begin
          strobe.capture = 1'b1;
          if (edgeInByte == 4'hF) strobe.writeBack = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCode   <= 2'b00;
      heldCpha  <= 1'b0;
      heldCpol  <= 1'b0;
      heldLsb   <= 1'b0;
      cntHeld   <= '0;
      byteIdx   <= '0;
      edgeNo    <= '0;
      divCnt    <= '0;
      csNReg    <= '1;
      doneReg   <= 1'b0;
      wrEnReg   <= 1'b0;
      wrAddrReg <= '0;
    end else begin
      doneReg <= 1'b0;
      wrEnReg <= strobe.writeBack;
      if (strobe.writeBack) wrAddrReg <= byteIdx[ADDR_W-1:0];
      case (state)
        ST_IDLE: begin
          if (startOk) begin
            state    <= ST_RUN;
            divCode  <= cfgWord[1:0];
            heldCpha <= cfgWord[CFG_CPHA_BIT];
            heldCpol <= cfgWord[CFG_CPOL_BIT];
            heldLsb  <= cfgWord[CFG_LSB_BIT];
            cntHeld  <= byteCount;
            csNReg   <= ~csSel;
            byteIdx  <= '0;
            edgeNo   <= '0;
            divCnt   <= '0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            divCnt <= '0;
            if (lastTick) begin
              csNReg <= '1;
              state  <= ST_DONE;
            end else begin
              edgeNo <= edgeNo + 1'b1;
              if (strobe.writeBack) byteIdx <= nextIdx;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_DONE: begin
          doneReg <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign csN       = csNReg;
  assign xferDone  = doneReg;
  assign bufWrEn   = wrEnReg;
  assign bufWrAddr = wrAddrReg;

  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csNReg) <= 1); // R12
  AST_CS_HELD_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) == ST_RUN) |-> $stable(csNReg)); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |->
      ($stable(divCode) && $stable(heldCpha) && $stable(heldCpol) && $stable(heldLsb))); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |=> !doneReg); // R10
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |-> ((&csNReg) && (&$past(csNReg)))); // R10
  AST_WR_IN_MESSAGE: assert property (@(posedge clk) disable iff (!rstN)
    wrEnReg |-> (CNT_W'(wrAddrReg) < cntHeld)); // R9
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (edgeNo <= {cntHeld, 4'b0000})); // R8

endmodule

// File: rtl/spi_eng_dpath.sv
module spi_eng_dpath
  import spi_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  engStrobe_t strobe,
  input  logic       heldCpha,
  input  logic       heldCpol,
  input  logic       heldLsb,
  input  logic [7:0] bufRdData,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] bufWrData
);

  logic [7:0] shiftReg;
  logic [7:0] rxReg;
  logic       sampleBit;
  logic       sckReg;

  // Phase 1 samples on the edge that closes the byte, so take MISO directly
  logic       rxBit;
  logic [7:0] shifted, rxByte;
  assign rxBit   = heldCpha ? miso : sampleBit;
  assign shifted = heldLsb ? {sampleBit, shiftReg[7:1]} : {shiftReg[6:0], sampleBit};
  assign rxByte  = heldLsb ? {rxBit, shiftReg[7:1]}     : {shiftReg[6:0], rxBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxReg     <= '0;
      sampleBit <= 1'b0;
      sckReg    <= 1'b0;
    end else begin
      if (strobe.start) begin
        sckReg    <= strobe.idleLvl;
        shiftReg  <= bufRdData;
        sampleBit <= 1'b0;
      end else begin
        if (strobe.toggle)    sckReg    <= ~sckReg;
        if (strobe.capture)   sampleBit <= miso;
        if (strobe.writeBack) rxReg     <= rxByte;
        if (strobe.load)      shiftReg  <= bufRdData;
        else if (strobe.shift) shiftReg <= shifted;
      end
    end
  end

  assign sck       = sckReg;
  assign mosi      = heldLsb ? shiftReg[0] : shiftReg[7];
  assign bufWrData = rxReg;

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.running |-> (sckReg == heldCpol)); // R5
  AST_NO_MOSI_MOVE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !(strobe.shift || strobe.load)); // R6
  AST_EDGE_WITH_DATA_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift || strobe.capture || strobe.load) |-> (strobe.toggle || strobe.start)); // R6

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int BUF_DEPTH = 200,
  parameter int ADDR_W    = $clog2(BUF_DEPTH),
  parameter int CNT_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        cfgWord,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [NUM_CS-1:0] csSel,
  output logic              xferDone,
  output logic [ADDR_W-1:0] bufRdAddr,
  input  logic [7:0]        bufRdData,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        bufWrData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);

  engStrobe_t strobe;
  logic heldCpha, heldCpol, heldLsb;

  spi_eng_ctrl #(
    .NUM_CS   (NUM_CS),
    .BUF_DEPTH(BUF_DEPTH),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWord  (cfgWord),
    .startReq (startReq),
    .byteCount(byteCount),
    .csSel    (csSel),
    .heldCpha (heldCpha),
    .heldCpol (heldCpol),
    .heldLsb  (heldLsb),
    .bufRdAddr(bufRdAddr),
    .bufWrEn  (bufWrEn),
    .bufWrAddr(bufWrAddr),
    .csN      (csN),
    .xferDone (xferDone),
    .strobe   (strobe)
  );

  spi_eng_dpath dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .heldCpha (heldCpha),
    .heldCpol (heldCpol),
    .heldLsb  (heldLsb),
    .bufRdData(bufRdData),
    .miso     (miso),
    .sck      (sck),
    .mosi     (mosi),
    .bufWrData(bufWrData)
  );

endmodule

// File: tb/spi_xfer_engine_test.sv
`timescale 1ns/1ps
module spi_xfer_engine_test;

  localparam int NCS    = 4;
  localparam int DEPTH  = 200;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:0]        cfgWord = 8'h00;
  logic              startReq = 1'b0;
  logic [CNT_W-1:0]  byteCount = '0;
  logic [NCS-1:0]    csSel = '0;
  logic              xferDone;
  logic [ADDR_W-1:0] bufRdAddr;
  logic [7:0]        bufRdData;
  logic              bufWrEn;
  logic [ADDR_W-1:0] bufWrAddr;
  logic [7:0]        bufWrData;
  logic              sck, mosi;
  logic              slaveMiso = 1'b0;
  logic [NCS-1:0]    csN;

  always #2.5 clk = ~clk;

  spi_xfer_engine #(.NUM_CS(NCS), .BUF_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .startReq(startReq),
    .byteCount(byteCount), .csSel(csSel), .xferDone(xferDone),
    .bufRdAddr(bufRdAddr), .bufRdData(bufRdData), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .sck(sck), .mosi(mosi),
    .miso(slaveMiso), .csN(csN)
  );

  // Buffer model
  logic [7:0] mem   [0:255];
  logic [7:0] txImg [0:255];
  logic       loadEn = 1'b0;
  assign bufRdData = mem[bufRdAddr];
  always @(posedge clk) begin
    if (loadEn) begin
      for (int i = 0; i < 256; i++) mem[i] <= txImg[i];
    end else if (bufWrEn) begin
      mem[bufWrAddr] <= bufWrData;
    end
  end

  // SPI slave model
  logic [7:0] sTx [0:255];
  logic [7:0] sRx [0:255];
  bit tcpol, tcpha, tlsb;
  bit csActive = 0;
  int lc, tc, dcnt, scnt;
  logic prevSck;
  logic [NCS-1:0] prevCs;

  function automatic int phys(int b);
    return tlsb ? b : 7 - b;
  endfunction

  always @(sck or csN) begin
    if (csN !== prevCs) begin
      if (csN != '1 && !csActive) begin
        csActive = 1; lc = 0; tc = 0; dcnt = 0; scnt = 0;
        if (!tcpha) begin slaveMiso = sTx[0][phys(0)]; dcnt = 1; end
      end else if (csN == '1) begin
        csActive = 0;
      end
    end
    if (sck !== prevSck && csActive) begin
      if (sck != tcpol) begin
        lc++;
        if (tcpha) begin slaveMiso = sTx[dcnt/8][phys(dcnt%8)]; dcnt++; end
        else begin sRx[scnt/8][phys(scnt%8)] = mosi; scnt++; end
      end else if (tc < lc) begin
        tc++;
        if (tcpha) begin sRx[scnt/8][phys(scnt%8)] = mosi; scnt++; end
        else if (dcnt < 2048) begin slaveMiso = sTx[(dcnt/8)%256][phys(dcnt%8)]; dcnt++; end
      end
    end
    prevSck = sck;
    prevCs  = csN;
  end

  // Monitor, sampled at the falling clock edge
  bit clrMon = 0;
  logic [NCS-1:0] expCs = '1;
  int cyc = 0;
  int edges, fallT, firstEdge, lastEdge, riseT, doneT, doneCnt, wrCnt, csErr, minGap, maxGap;
  bit pCsAct = 0;
  logic pSck = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (clrMon) begin
      edges = 0; fallT = -1; firstEdge = -1; lastEdge = -1; riseT = -1;
      doneT = -1; doneCnt = 0; wrCnt = 0; csErr = 0; minGap = 1000000; maxGap = 0;
    end else begin
      if (csN != '1 && !pCsAct) fallT = cyc;
      if (csN == '1 && pCsAct) riseT = cyc;
      if (csN != '1 && pCsAct && sck != pSck) begin
        edges++;
        if (firstEdge < 0) firstEdge = cyc;
        else begin
          if (cyc - lastEdge < minGap) minGap = cyc - lastEdge;
          if (cyc - lastEdge > maxGap) maxGap = cyc - lastEdge;
        end
        lastEdge = cyc;
      end
      if (csN != '1 && csN != expCs) csErr++;
      if (xferDone) begin doneCnt++; doneT = cyc; end
      if (bufWrEn) wrCnt++;
    end
    pCsAct = (csN != '1);
    pSck   = sck;
  end

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int halfOf(input logic [1:0] code);
    case (code)
      2'b00: return 2;
      2'b01: return 8;
      2'b10: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic logic [7:0] txPat(int seed, int i);
    return 8'((i * 37 + seed * 11 + 5) & 255);
  endfunction
  function automatic logic [7:0] rxPat(int seed, int i);
    return 8'(((i * 91 + seed * 53 + 167) ^ (i >> 1)) & 255);
  endfunction

  task automatic clearMon();
    @(posedge clk); #1 clrMon = 1;
    @(posedge clk); #1 clrMon = 0;
  endtask

  task automatic runMsg(input logic [7:0] cfg, input int n, input int csIdx, input bit disturb, input int seed);
    int h, txBad, rxBad, firstBadTx, firstBadRx, limit;
    h = halfOf(cfg[1:0]);
    for (int i = 0; i < 256; i++) begin
      txImg[i] = (i < n) ? txPat(seed, i) : 8'hC3;
      sTx[i]   = rxPat(seed, i);
      sRx[i]   = ~txImg[i];
    end
    @(posedge clk); #1 loadEn = 1;
    @(posedge clk); #1 loadEn = 0;
    tcpol = cfg[3]; tcpha = cfg[2]; tlsb = cfg[5];
    expCs = ~(NCS'(1) << csIdx);
    clearMon();
    cfgWord = cfg; byteCount = CNT_W'(n); csSel = NCS'(1) << csIdx; startReq = 1;
    @(posedge clk); #1 startReq = 0;
    if (disturb) begin
      repeat (20) @(posedge clk);
      #1 cfgWord = cfg ^ 8'h2D; csSel = NCS'(1) << ((csIdx + 1) % NCS);
      byteCount = CNT_W'(1); startReq = 1;
      @(posedge clk); #1 startReq = 0;
    end
    limit = n * 16 * h + 400;
    for (int k = 0; k < limit && doneCnt == 0; k++) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    txBad = 0; rxBad = 0; firstBadTx = -1; firstBadRx = -1;
    for (int i = 0; i < n; i++) begin
      if (sRx[i] !== txPat(seed, i)) begin txBad++; if (firstBadTx < 0) firstBadTx = i; end
      if (mem[i] !== rxPat(seed, i)) begin rxBad++; if (firstBadRx < 0) firstBadRx = i; end
    end
    chk(txBad == 0, "R6/R7", $sformatf("cfg %02h bytes sent to slave (first bad idx %0d)", cfg, firstBadTx), txBad, 0);
    chk(rxBad == 0, "R9", $sformatf("cfg %02h bytes written back (first bad idx %0d)", cfg, firstBadRx), rxBad, 0);
    chk(edges == 16 * n, "R8", $sformatf("cfg %02h SCK edge count", cfg), edges, 16 * n);
    chk(firstEdge - fallT == h, "R4", $sformatf("cfg %02h CS-to-first-edge cycles", cfg), firstEdge - fallT, h);
    chk(riseT - lastEdge == h, "R4", $sformatf("cfg %02h last-edge-to-release cycles", cfg), riseT - lastEdge, h);
    chk(minGap == h && maxGap == h, "R4", $sformatf("cfg %02h half period min/max %0d/%0d", cfg, minGap, maxGap), maxGap, h);
    chk(doneCnt == 1 && doneT - riseT == 1, "R10", $sformatf("cfg %02h done pulse count %0d offset", cfg, doneCnt), doneT - riseT, 1);
    chk(csErr == 0 && fallT >= 0, "R12", $sformatf("cfg %02h wrong csN pattern samples", cfg), csErr, 0);
    chk(sck == cfg[3], "R5", $sformatf("cfg %02h idle SCK after message", cfg), int'(sck), int'(cfg[3]));
    chk(wrCnt == n, "R9", $sformatf("cfg %02h write strobe count", cfg), wrCnt, n);
    if (n < 256) chk(mem[n] == 8'hC3, "R9", "entry past message untouched", int'(mem[n]), 8'hC3);
  endtask

  task automatic ignoredStart(input int cnt, input logic [NCS-1:0] sel, input string why);
    clearMon();
    cfgWord = 8'h00; byteCount = CNT_W'(cnt); csSel = sel; startReq = 1;
    @(posedge clk); #1 startReq = 0;
    repeat (40) @(posedge clk);
    @(negedge clk); #1;
    chk(fallT < 0 && csN == '1, "R3", {why, ": csN activity"}, fallT, -1);
    chk(doneCnt == 0 && wrCnt == 0, "R3", {why, ": done/write count"}, doneCnt + wrCnt, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk); #1;
    chk(csN == '1, "R1", "csN after reset", int'(csN), (1 << NCS) - 1);
    chk(sck == 1'b0 && xferDone == 1'b0 && bufWrEn == 1'b0, "R1", "sck/done/wr after reset",
        int'({sck, xferDone, bufWrEn}), 0);

    // R2 acceptance is exercised by every message below; R3 rejections first
    ignoredStart(0, 4'b0001, "zero count");
    ignoredStart(DEPTH + 1, 4'b0010, "count above depth");
    ignoredStart(3, 4'b0000, "no chip select");
    ignoredStart(3, 4'b0110, "two chip selects");

    // Sweep of phase, polarity, bit order and divider (R4..R8)
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 4; d++) begin
        logic [7:0] cfg;
        cfg = 8'(d) | (m[0] ? 8'h04 : 8'h00) | (m[1] ? 8'h08 : 8'h00) | (m[2] ? 8'h20 : 8'h00);
        runMsg(cfg, (d < 2) ? 3 : 2, (m + d) % NCS, (m == 5 && d == 1), m * 4 + d);
      end
    end

    // R11: config, select and start disturbed mid-message
    runMsg(8'h2E, 2, 3, 1'b1, 77);
    // Boundary lengths: one byte, and a full buffer (R2, R8)
    runMsg(8'h27, 1, 1, 1'b0, 91);
    runMsg(8'h08, DEPTH, 2, 1'b0, 13);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule